// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block drives an active-low processor reset from two sources. The first is a supply-good flag that an external comparator produces; that comparator already applies its own hysteresis. The second is a watchdog on a service input that can sit in one of three states: low, high or floating. The input arrives as a 2-bit code. The block counts clock ticks to time both the watchdog period and the minimum reset pulse width, and both durations are parameters.

While the supply is bad, the reset stays asserted. When the supply returns, the reset is held for a fixed pulse width. While the processor runs, it must keep toggling the service input between low and high. If the input sits at one level longer than the timeout, the block issues a reset pulse, and it keeps issuing one each period until service resumes. A floating service input switches the watchdog off. A sticky fault flag records that a watchdog reset has happened.

Both inputs pass through a two-flop synchronizer. Any change at an input therefore reaches the outputs three clocks later.

Top module: `wdog_supervisor`

## Requirements
- R1: While the supply-good flag is low, resetN is low. A falling supply-good input drives resetN low on the third rising clock edge after the change. A rising edge of resetN always follows at least PULSE_TICKS cycles in which resetN was low while the synchronized supply was good.
- R2: When supply-good rises, resetN stays low for exactly PULSE_TICKS+2 clock cycles after the input change and then goes high.
- R3: The service code is 2'b00 for low and 2'b01 for high. Any code with bit 1 set means floating. While the code is floating, no watchdog reset occurs, however long it lasts.
- R4: A change of the service code between low and high, in either direction, restarts the watchdog count from zero. Toggling faster than the timeout keeps resetN high. After a toggle, resetN stays high for exactly TIMEOUT_TICKS+2 cycles if no further toggle follows.
- R5: If the service code stays at one driven level, resetN goes low TIMEOUT_TICKS+2 cycles after the last change of the code.
- R6: Each watchdog-triggered reset holds resetN low for exactly PULSE_TICKS cycles.
- R7: A change between floating and a driven level is not a service edge and does not clear the fault flag. Entering a driven level restarts the watchdog count from zero.
- R8: The watchdog count is held at zero while resetN is low and starts at release. Without service, resetN stays high for exactly TIMEOUT_TICKS cycles after each release, so unserviced operation repeats with a period of TIMEOUT_TICKS+PULSE_TICKS.
- R9: A supply failure during a watchdog pulse takes priority. resetN stays low for the whole failure, and the full pulse (PULSE_TICKS+2 cycles from the input change) starts again when the supply returns.
- R10: wdFault is 0 after rst_n. It rises together with each watchdog-triggered reset, stays set, and clears on the cycle after a low/high service edge is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the tick that times both durations |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| supplyGood | input | 1 | Supply-good flag from the external comparator, asynchronous |
| serviceCode | input | 2 | Watchdog service state: 00 low, 01 high, 1x floating |
| resetN | output | 1 | Active-low processor reset |
| wdFault | output | 1 | Sticky flag: a watchdog-triggered reset has happened |

## Verification
The service input is tried in four patterns. A long float shows that the watchdog is disabled. Toggling faster than the timeout shows that both edge directions count as service. A frozen driven level yields the periodic pulse train, whose high and low lengths are measured exactly. A float-to-driven step shows that the step restarts the count but leaves the fault flag set. Supply steps are applied during the run state, during a watchdog pulse and across a long outage. These tell the latency of reset assertion, the restart of the pulse width after a power failure, and the timer hold during reset apart from a timer that keeps counting.

// File: rtl/svr_pkg.sv
package svr_pkg;

  typedef enum logic [1:0] {
    ST_POWER_BAD = 2'd0,
    ST_PULSE     = 2'd1,
    ST_RUN       = 2'd2
  } svr_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wdClear;
    logic wdInc;
    logic pulseClear;
    logic pulseInc;
    logic faultSet;
    logic faultClr;
  } svr_ctrl_t;

  // service code: bit 1 set means floating, bit 0 is the driven level
  localparam logic [1:0] CODE_FLOAT = 2'b10;

endpackage

// File: rtl/svr_sync.sv
module svr_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RESET_VAL;
    else        chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RESET_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/svr_datapath.sv
module svr_datapath
  import svr_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 1600000,
  parameter int PULSE_TICKS = 140000,
  localparam int WD_W = ($clog2(TIMEOUT_TICKS) > 0) ? $clog2(TIMEOUT_TICKS) : 1,
  localparam int PL_W = ($clog2(PULSE_TICKS) > 0) ? $clog2(PULSE_TICKS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  svr_ctrl_t       ctrl,
  input  logic [1:0]      syncCode,
  output logic            driven,
  output logic            serviceEdge,
  output logic            enterDriven,
  output logic            wdDone,
  output logic            pulseDone,
  output logic            wdFault,
  output logic [WD_W-1:0] wdCount
);

  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT_TICKS - 1);
  localparam logic [PL_W-1:0] PL_LAST = PL_W'(PULSE_TICKS - 1);

  logic [1:0]      prevCode;
  logic            prevDriven;
  logic [WD_W-1:0] wdCnt;
  logic [PL_W-1:0] pulseCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevCode <= CODE_FLOAT;
    else        prevCode <= syncCode;
  end

  assign driven      = ~syncCode[1];
  assign prevDriven  = ~prevCode[1];
  assign serviceEdge = driven && prevDriven && (syncCode[0] != prevCode[0]);
  assign enterDriven = driven && !prevDriven;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wdCnt <= '0;
    else if (ctrl.wdClear) wdCnt <= '0;
    else if (ctrl.wdInc)   wdCnt <= wdCnt + WD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pulseCnt <= '0;
    else if (ctrl.pulseClear) pulseCnt <= '0;
    else if (ctrl.pulseInc)   pulseCnt <= pulseCnt + PL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             wdFault <= 1'b0;
    else if (ctrl.faultSet) wdFault <= 1'b1;
    else if (ctrl.faultClr) wdFault <= 1'b0;
  end

  assign wdDone    = (wdCnt == WD_LAST);
  assign pulseDone = (pulseCnt == PL_LAST);
  assign wdCount   = wdCnt;

endmodule

// File: rtl/svr_control.sv
module svr_control
  import svr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      syncGood,
  input  logic      driven,
  input  logic      serviceEdge,
  input  logic      enterDriven,
  input  logic      wdDone,
  input  logic      pulseDone,
  output svr_ctrl_t ctrl,
  output logic      resetN
);

  svr_state_e state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_POWER_BAD;
    else        state <= nextState;
  end

  always_comb begin
    ctrl = '0;
    nextState = state;
    ctrl.faultClr = serviceEdge;
    case (state)
      ST_POWER_BAD: begin
        ctrl.wdClear = 1'b1;
        ctrl.pulseClear = 1'b1;
        if (syncGood) nextState = ST_PULSE;
      end
      ST_PULSE: begin
        ctrl.wdClear = 1'b1;
        if (pulseDone) begin
          ctrl.pulseClear = 1'b1;
          nextState = ST_RUN;
        end else begin
          ctrl.pulseInc = 1'b1;
        end
      end
      ST_RUN: begin
        ctrl.pulseClear = 1'b1;
        if (!driven || serviceEdge || enterDriven) begin
          ctrl.wdClear = 1'b1;
        end else if (wdDone) begin
          ctrl.wdClear = 1'b1;
          ctrl.faultSet = 1'b1;
          nextState = ST_PULSE;
        end else begin
          ctrl.wdInc = 1'b1;
        end
      end
      default: nextState = ST_POWER_BAD;
    endcase
    // a bad supply overrides every other decision
    if (!syncGood) begin
      nextState = ST_POWER_BAD;
      ctrl.wdClear = 1'b1;
      ctrl.wdInc = 1'b0;
      ctrl.pulseClear = 1'b1;
      ctrl.pulseInc = 1'b0;
      ctrl.faultSet = 1'b0;
    end
  end

  assign resetN = (state == ST_RUN);

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import svr_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 1600000,
  parameter int PULSE_TICKS = 140000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supplyGood,
  input  logic [1:0] serviceCode,
  output logic       resetN,
  output logic       wdFault
);

  localparam int WD_W = ($clog2(TIMEOUT_TICKS) > 0) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [2:0] SYNC_INIT = {1'b0, CODE_FLOAT};

  logic [2:0]      syncBus;
  logic            syncGood;
  logic [1:0]      syncCode;
  svr_ctrl_t       ctrl;
  logic            drivenLvl;
  logic            serviceEdge;
  logic            enterDriven;
  logic            wdDone;
  logic            pulseDone;
  logic [WD_W-1:0] wdCount;

  svr_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(SYNC_INIT)
  ) u_sync (
    .clk(clk),
    .rst_n(rst_n),
    .asyncIn({supplyGood, serviceCode}),
    .syncOut(syncBus)
  );

  assign syncGood = syncBus[2];
  assign syncCode = syncBus[1:0];

  svr_datapath #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .PULSE_TICKS(PULSE_TICKS)
  ) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .ctrl(ctrl),
    .syncCode(syncCode),
    .driven(drivenLvl),
    .serviceEdge(serviceEdge),
    .enterDriven(enterDriven),
    .wdDone(wdDone),
    .pulseDone(pulseDone),
    .wdFault(wdFault),
    .wdCount(wdCount)
  );

  svr_control u_ctl (
    .clk(clk),
    .rst_n(rst_n),
    .syncGood(syncGood),
    .driven(drivenLvl),
    .serviceEdge(serviceEdge),
    .enterDriven(enterDriven),
    .wdDone(wdDone),
    .pulseDone(pulseDone),
    .ctrl(ctrl),
    .resetN(resetN)
  );

endmodule

// File: rtl/svr_checker.sv
module svr_checker #(
  parameter int PULSE_TICKS = 8,
  parameter int WD_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            syncGood,
  input logic            driven,
  input logic            serviceEdge,
  input logic            resetN,
  input logic            wdFault,
  input logic [WD_W-1:0] wdCount
);

  localparam int LW = $clog2(PULSE_TICKS + 1) + 1;
  localparam logic [LW-1:0] P_SAT = LW'(PULSE_TICKS);

  // saturating count of consecutive low-reset cycles with good supply
  logic [LW-1:0] lowRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 lowRun <= '0;
    else if (resetN || !syncGood) lowRun <= '0;
    else if (lowRun < P_SAT)    lowRun <= lowRun + LW'(1);
  end

  p_bad_supply_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !syncGood |=> !resetN);

  p_min_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetN) |-> lowRun == P_SAT);

  p_float_no_wd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resetN && syncGood && !driven) |=> resetN);

  p_timer_zero_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetN) |-> wdCount == '0);

  p_edge_clears_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    serviceEdge |=> !wdFault);

  p_fault_with_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdFault) |-> !resetN);

endmodule

bind wdog_supervisor svr_checker #(
  .PULSE_TICKS(PULSE_TICKS),
  .WD_W(WD_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .syncGood(syncGood),
  .driven(drivenLvl),
  .serviceEdge(serviceEdge),
  .resetN(resetN),
  .wdFault(wdFault),
  .wdCount(wdCount)
);

// File: tb/sim_wdog_supervisor.sv
module sim_wdog_supervisor;

  localparam int T = 20;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supplyGood = 1'b0;
  logic [1:0] serviceCode = 2'b10;
  logic       resetN;
  logic       wdFault;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdog_supervisor #(
    .TIMEOUT_TICKS(T),
    .PULSE_TICKS(P),
    .SYNC_STAGES(2)
  ) u0 (
    .clk(clk),
    .rst_n(rst_n),
    .supplyGood(supplyGood),
    .serviceCode(serviceCode),
    .resetN(resetN),
    .wdFault(wdFault)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedge samples, starting with the current one, while resetN holds lvl
  task automatic runLen(input logic lvl, output int n);
    n = 0;
    while (resetN === lvl && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic toggleLevel();
    serviceCode = {1'b0, ~serviceCode[0]};
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    check(resetN === 1'b0, "R1 reset state resetN", int'(resetN), 0);
    check(wdFault === 1'b0, "R10 reset state wdFault", int'(wdFault), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(resetN === 1'b0, "R1 supply bad after reset", int'(resetN), 0);
  endtask

  task automatic tPowerUp();
    int n;
    int bad;
    supplyGood = 1'b1;
    @(negedge clk);
    runLen(1'b0, n);
    check(n == P + 2, "R2 power-up pulse length", n, P + 2);
    bad = 0;
    repeat (3 * T) begin
      if (resetN !== 1'b1) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R3 floating code gives no reset", bad, 0);
  endtask

  task automatic tServiceKeep();
    int bad;
    bad = 0;
    serviceCode = 2'b00;
    repeat (6) begin
      repeat (T / 2) begin
        @(negedge clk);
        if (resetN !== 1'b1) bad++;
      end
      toggleLevel();
    end
    check(bad == 0, "R4 toggling keeps resetN high", bad, 0);
    check(wdFault === 1'b0, "R10 no fault while serviced", int'(wdFault), 0);
  endtask

  task automatic tTimeout();
    int n;
    @(negedge clk);
    runLen(1'b1, n);
    check(n == T + 2, "R5 timeout after last change", n, T + 2);
    runLen(1'b0, n);
    check(n == P, "R6 first watchdog pulse width", n, P);
    check(wdFault === 1'b1, "R10 fault set by watchdog reset", int'(wdFault), 1);
    runLen(1'b1, n);
    check(n == T, "R8 high time after release", n, T);
    runLen(1'b0, n);
    check(n == P, "R6 repeated watchdog pulse width", n, P);
  endtask

  task automatic tFloatNotService();
    int n;
    logic lastLvl;
    lastLvl = serviceCode[0];
    serviceCode = 2'b10;
    repeat (5) @(negedge clk);
    serviceCode = {1'b0, ~lastLvl};
    repeat (4) @(negedge clk);
    check(wdFault === 1'b1, "R7 float to driven keeps fault", int'(wdFault), 1);
    runLen(1'b1, n);
    check(n == T - 1, "R7 driven entry restarts timer", n, T - 1);
  endtask

  task automatic tFaultClear();
    int n;
    runLen(1'b0, n);
    check(n == P, "R6 pulse after driven entry", n, P);
    toggleLevel();
    repeat (4) @(negedge clk);
    check(wdFault === 1'b0, "R10 service edge clears fault", int'(wdFault), 0);
  endtask

  task automatic tRestart();
    int n;
    repeat (T - 8) @(negedge clk);
    toggleLevel();
    @(negedge clk);
    runLen(1'b1, n);
    check(n == T + 2, "R4 toggle restarts timer", n, T + 2);
  endtask

  task automatic tPowerFailInPulse();
    int n;
    int bad;
    supplyGood = 1'b0;
    bad = 0;
    repeat (12) begin
      @(negedge clk);
      if (resetN !== 1'b0) bad++;
    end
    check(bad == 0, "R9 low through failure in pulse", bad, 0);
    supplyGood = 1'b1;
    @(negedge clk);
    runLen(1'b0, n);
    check(n == P + 2, "R9 pulse restarts after return", n, P + 2);
  endtask

  task automatic tPowerFailRun();
    int n;
    int bad;
    repeat (3) @(negedge clk);
    supplyGood = 1'b0;
    repeat (2) @(negedge clk);
    check(resetN === 1'b1, "R1 still high two edges after drop", int'(resetN), 1);
    @(negedge clk);
    check(resetN === 1'b0, "R1 low on third edge after drop", int'(resetN), 0);
    bad = 0;
    repeat (2 * T) begin
      @(negedge clk);
      if (resetN !== 1'b0) bad++;
    end
    check(bad == 0, "R1 held low while supply bad", bad, 0);
    supplyGood = 1'b1;
    @(negedge clk);
    runLen(1'b0, n);
    check(n == P + 2, "R2 pulse after outage", n, P + 2);
    runLen(1'b1, n);
    check(n == T, "R8 timer held during outage", n, T);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tReset();
    tPowerUp();
    tServiceKeep();
    tTimeout();
    tFloatNotService();
    tFaultClear();
    tRestart();
    tPowerFailInPulse();
    tPowerFailRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule